// File: doc/BRIEF.md
# Byte-wide UART register unit with status and interrupt flags

This block is a serial port that a processor reaches through a small byte-wide register window. A single data address fronts two separate storage registers. A write stores a byte for transmission, and a read returns the last byte received. A read-only status byte reports five conditions:

- a received byte is waiting;
- a transmission has fully drained;
- the transmit buffer can take a byte;
- the last received byte had a bad stop bit;
- a byte arrived while the previous one was still unread.

A control byte enables the two interrupt requests.

The line format is 8N1: one low start bit, eight data bits sent least significant bit first, and one high stop bit. Each bit lasts 16 pulses of an externally supplied baud tick. The transmitter is double-buffered, so software can queue the next byte while the current one shifts out. The receiver checks the start bit at its midpoint and samples each data bit at mid-bit.

Top module: `serial_port_regs`

## Requirements
- R1: Address 0 is the data address. A write there loads the transmit buffer and does not change the value a read returns. A read there returns the receive buffer.
- R2: When a received frame completes, its byte enters the receive buffer and status bit 7 (receive ready) sets. This happens whether or not the stop bit was high. Status bit 4 (frame error) reads 1 exactly when that frame's stop bit was sampled low.
- R3: Receive ready clears only on a read of address 0. While it stays set and the receive interrupt is enabled, `irq_rx` stays high.
- R4: Status bit 6 (transmit done) sets when a stop bit finishes and the transmit buffer holds no waiting byte. It stays clear when a queued byte follows at once.
- R5: Transmit done clears on `irq_ack_tx` or on a write to address 1 with data bit 6 set. A write to address 1 with bit 6 clear leaves it unchanged.
- R6: Status bit 5 (buffer empty) is 1 after reset. It reads 0 right after a data write and returns to 1 when the byte moves into the shifter.
- R7: Status bit 3 (overrun) sets when a frame completes while receive ready is still set. The unread byte is kept, and the next read of address 0 clears the flag.
- R8: Address 2 is the control byte, readable back. Bit 7 enables `irq_rx`, which is high while receive ready is set. Bit 6 enables `irq_tx`, which is high while transmit done is set. Status bits 2..0 read 0.
- R9: `serial_out` idles high. A frame is one low start bit, eight data bits LSB first, and a high stop bit, each 16 baud ticks long.
- R10: A low pulse on `serial_in` that has ended before the middle of the start bit produces no received byte.
- R11: After reset the status byte reads 0x20, the control byte reads 0x00, both interrupts are low and `serial_out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a data read clears receive flags |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_ack_tx | input | 1 | Transmit interrupt acknowledge |
| serial_in | input | 1 | Serial receive line |
| serial_out | output | 1 | Serial transmit line |

## Verification
The embedded assertions watch the following on every cycle:

- receive ready drops after a data read;
- the empty flag drops after a data write;
- transmit done rises only when no byte was queued;
- acknowledge clears transmit done;
- the receive buffer holds still on overrun;
- a rejected start goes back to idle;
- each transmitted frame starts low and ends high.

Some behaviour only the bench's scenarios can show, because it spans whole frames. Decoding the transmitted bit order and values against a scoreboard is one such case. So is the frame-error value for a bad stop bit. Others are the byte kept across an overrun, glitch rejection seen at the status port, and the interrupt masking.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int DATA_W   = 8;
  localparam int OVERSAMP = 16;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam int ST_RXRDY = 7;
  localparam int ST_TXDON = 6;
  localparam int ST_EMPTY = 5;
  localparam int ST_FERR  = 4;
  localparam int ST_OVRUN = 3;

  localparam int CT_RXEN = 7;
  localparam int CT_TXEN = 6;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/sp_rst_sync.sv
module sp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int OVS   = OVERSAMP,
  parameter int SYNCS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line_in,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          stop_bit
);
  localparam int CW  = $clog2(OVS);
  localparam int BW  = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] CNT_MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

  logic [SYNCS-1:0] sync_q;
  logic             line;
  rx_state_e        state_q, state_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [BW-1:0]    bit_q, bit_n;
  logic [DW-1:0]    sh_q, sh_n;
  logic             done_q, done_n;
  logic             stop_q, stop_n;

  generate
    if (SYNCS == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= line_in;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNCS-2:0], line_in};
      end
    end
  endgenerate

  assign line = sync_q[SYNCS-1];

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    bit_n   = bit_q;
    sh_n    = sh_q;
    stop_n  = stop_q;
    done_n  = 1'b0;
    if (tick) begin
      unique case (state_q)
        RX_IDLE: begin
          if (!line) begin
            state_n = RX_START;
            cnt_n   = '0;
          end
        end
        RX_START: begin
          if (cnt_q == CNT_MID) begin
            cnt_n   = '0;
            bit_n   = '0;
            state_n = line ? RX_IDLE : RX_DATA;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == CNT_LAST) begin
            cnt_n = '0;
            sh_n  = {line, sh_q[DW-1:1]};
            if (bit_q == BIT_LAST) state_n = RX_STOP;
            else                   bit_n   = bit_q + 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == CNT_LAST) begin
            cnt_n   = '0;
            done_n  = 1'b1;
            stop_n  = line;
            state_n = RX_IDLE;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: state_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      done_q  <= 1'b0;
      stop_q  <= 1'b1;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      bit_q   <= bit_n;
      sh_q    <= sh_n;
      done_q  <= done_n;
      stop_q  <= stop_n;
    end
  end

  assign done     = done_q;
  assign data     = sh_q;
  assign stop_bit = stop_q;

  // R10: a start that is high again at its midpoint is abandoned
  a_r10_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && tick && cnt_q == CNT_MID && line) |=> state_q == RX_IDLE);

  // R2: completion is a single-cycle event
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/sp_tx.sv
module sp_tx
  import sp_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int OVS = OVERSAMP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] data,
  output logic          ready,
  output logic          done,
  output logic          line_out
);
  localparam int FW  = DW + 2;
  localparam int CW  = $clog2(OVS);
  localparam int BCW = $clog2(FW);
  localparam logic [CW-1:0]  CNT_LAST = CW'(OVS - 1);
  localparam logic [BCW-1:0] BIT_LAST = BCW'(FW - 1);

  logic           busy_q, busy_n;
  logic [FW-1:0]  sh_q, sh_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic [BCW-1:0] bit_q, bit_n;
  logic           done_q, done_n;

  always_comb begin
    busy_n = busy_q;
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    bit_n  = bit_q;
    done_n = 1'b0;
    if (load && !busy_q) begin
      busy_n = 1'b1;
      sh_n   = {1'b1, data, 1'b0};
      cnt_n  = '0;
      bit_n  = '0;
    end else if (busy_q && tick) begin
      if (cnt_q == CNT_LAST) begin
        cnt_n = '0;
        sh_n  = {1'b1, sh_q[FW-1:1]};
        if (bit_q == BIT_LAST) begin
          busy_n = 1'b0;
          done_n = 1'b1;
        end else begin
          bit_n = bit_q + 1'b1;
        end
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      bit_q  <= bit_n;
      done_q <= done_n;
    end
  end

  assign ready    = !busy_q;
  assign done     = done_q;
  assign line_out = busy_q ? sh_q[0] : 1'b1;

  // R9: every frame opens with a low start bit
  a_r9_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !line_out);

  // R9: the bit just before completion was the high stop bit
  a_r9_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(line_out));
endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import sp_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int OVS   = OVERSAMP,
  parameter int SYNCS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_rx,
  output logic          irq_tx,
  input  logic          irq_ack_tx,
  input  logic          serial_in,
  output logic          serial_out
);
  logic          rst_i_n;
  logic          rx_done, rx_stop;
  logic [DW-1:0] rx_byte;
  logic          tx_ready, tx_done, tx_load;

  logic [DW-1:0] rxbuf_q, rxbuf_n;
  logic          rxrdy_q, rxrdy_n;
  logic          ferr_q, ferr_n;
  logic          ovr_q, ovr_n;
  logic [DW-1:0] txbuf_q, txbuf_n;
  logic          empty_q, empty_n;
  logic          txdon_q, txdon_n;
  logic          rxen_q, rxen_n;
  logic          txen_q, txen_n;

  logic rd_data, wr_data, wr_stat, wr_ctrl;

  sp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sp_rx #(.DW(DW), .OVS(OVS), .SYNCS(SYNCS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .tick     (baud_tick),
    .line_in  (serial_in),
    .done     (rx_done),
    .data     (rx_byte),
    .stop_bit (rx_stop)
  );

  sp_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .tick     (baud_tick),
    .load     (tx_load),
    .data     (txbuf_q),
    .ready    (tx_ready),
    .done     (tx_done),
    .line_out (serial_out)
  );

  assign rd_data = bus_rd && (bus_addr == ADDR_DATA);
  assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
  assign wr_stat = bus_wr && (bus_addr == ADDR_STAT);
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign tx_load = !empty_q && tx_ready;

  always_comb begin
    rxbuf_n = rxbuf_q;
    rxrdy_n = rxrdy_q;
    ferr_n  = ferr_q;
    ovr_n   = ovr_q;
    if (rd_data) begin
      rxrdy_n = 1'b0;
      ovr_n   = 1'b0;
    end
    if (rx_done) begin
      if (rxrdy_q && !rd_data) begin
        ovr_n = 1'b1;
      end else begin
        rxbuf_n = rx_byte;
        ferr_n  = !rx_stop;
        rxrdy_n = 1'b1;
      end
    end
  end

  always_comb begin
    txbuf_n = txbuf_q;
    empty_n = empty_q;
    txdon_n = txdon_q;
    rxen_n  = rxen_q;
    txen_n  = txen_q;
    if (tx_load) empty_n = 1'b1;
    if (wr_data) begin
      txbuf_n = bus_wdata;
      empty_n = 1'b0;
    end
    if (irq_ack_tx || (wr_stat && bus_wdata[ST_TXDON])) txdon_n = 1'b0;
    if (tx_done && empty_q) txdon_n = 1'b1;
    if (wr_ctrl) begin
      rxen_n = bus_wdata[CT_RXEN];
      txen_n = bus_wdata[CT_TXEN];
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rxbuf_q <= '0;
      rxrdy_q <= 1'b0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
      txbuf_q <= '0;
      empty_q <= 1'b1;
      txdon_q <= 1'b0;
      rxen_q  <= 1'b0;
      txen_q  <= 1'b0;
    end else begin
      rxbuf_q <= rxbuf_n;
      rxrdy_q <= rxrdy_n;
      ferr_q  <= ferr_n;
      ovr_q   <= ovr_n;
      txbuf_q <= txbuf_n;
      empty_q <= empty_n;
      txdon_q <= txdon_n;
      rxen_q  <= rxen_n;
      txen_q  <= txen_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_DATA: bus_rdata = rxbuf_q;
      ADDR_STAT: begin
        bus_rdata[ST_RXRDY] = rxrdy_q;
        bus_rdata[ST_TXDON] = txdon_q;
        bus_rdata[ST_EMPTY] = empty_q;
        bus_rdata[ST_FERR]  = ferr_q;
        bus_rdata[ST_OVRUN] = ovr_q;
      end
      ADDR_CTRL: begin
        bus_rdata[CT_RXEN] = rxen_q;
        bus_rdata[CT_TXEN] = txen_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign irq_rx = rxrdy_q && rxen_q;
  assign irq_tx = txdon_q && txen_q;

  // R3: a data read with no arrival in the same cycle drops receive ready
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_data && !rx_done) |=> !rxrdy_q);

  // R6: the buffer is reported full right after a data write
  a_r6_write_fills: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_data |=> !empty_q);

  // R4: transmit done only rises when nothing was queued
  a_r4_done_needs_empty: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(txdon_q) |-> $past(empty_q));

  // R5: acknowledge without a new completion clears transmit done
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_i_n)
    (irq_ack_tx && !tx_done) |=> !txdon_q);

  // R7: an overrun arrival leaves the unread byte in place
  a_r7_keep_unread: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rx_done && rxrdy_q && !rd_data) |=> ($stable(rxbuf_q) && ovr_q));
endmodule

// File: tb/serial_port_regs_test.sv
module serial_port_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_rx, irq_tx;
  logic       irq_ack_tx = 1'b0;
  logic       serial_in = 1'b1;
  logic       serial_out;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] exp_q[$];
  int   tick_div = 0;
  bit   mon_on = 1'b0;

  localparam int BITCLK = 64;

  serial_port_regs uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_ack_tx(irq_ack_tx),
    .serial_in(serial_in), .serial_out(serial_out)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tick_div  <= (tick_div == 3) ? 0 : tick_div + 1;
    baud_tick <= (tick_div == 3);
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    logic [9:0] f;
    f = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      serial_in = f[i];
      repeat (BITCLK - 1) @(negedge clk);
    end
    @(negedge clk);
    serial_in = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic queue_tx(input logic [7:0] b);
    exp_q.push_back(b);
    bus_write(2'd0, b);
  endtask

  // scoreboard monitor: decode each frame on serial_out (R9)
  initial begin
    logic [7:0] got;
    logic [7:0] want;
    forever begin
      @(negedge clk);
      if (mon_on && serial_out === 1'b0) begin
        repeat (BITCLK/2) @(negedge clk);
        check("R9 start bit", {7'd0, serial_out}, 8'h00);
        for (int i = 0; i < 8; i++) begin
          repeat (BITCLK) @(negedge clk);
          got[i] = serial_out;
        end
        repeat (BITCLK) @(negedge clk);
        check("R9 stop bit", {7'd0, serial_out}, 8'h01);
        if (exp_q.size() == 0) want = 8'hxx;
        else want = exp_q.pop_front();
        check("R9 frame data", got, want);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_on = 1'b1;

    // R11 reset state
    bus_read(2'd1, d); check("R11 status", d, 8'h20);
    bus_read(2'd2, d); check("R11 control", d, 8'h00);
    check("R11 lines", {5'd0, irq_rx, irq_tx, serial_out}, 8'h01);

    // R8 control readback
    bus_write(2'd2, 8'hC0);
    bus_read(2'd2, d); check("R8 control", d, 8'hC0);

    // R2 good frame
    send_frame(8'hA5, 1'b1);
    bus_read(2'd1, d); check("R2 status", d, 8'hA0);
    check("R8 irq_rx on", {7'd0, irq_rx}, 8'h01);
    repeat (20) @(negedge clk);
    check("R3 irq_rx holds", {7'd0, irq_rx}, 8'h01);
    bus_read(2'd0, d); check("R1 read data", d, 8'hA5);
    bus_read(2'd1, d); check("R3 rxrdy cleared", d, 8'h20);
    check("R3 irq_rx off", {7'd0, irq_rx}, 8'h00);

    // R2 framing error still delivers
    send_frame(8'h3C, 1'b0);
    bus_read(2'd1, d); check("R2 ferr status", d, 8'hB0);
    bus_read(2'd0, d); check("R2 ferr data", d, 8'h3C);

    // R7 overrun
    send_frame(8'h11, 1'b1);
    send_frame(8'h22, 1'b1);
    bus_read(2'd1, d); check("R7 overrun set", d, 8'hA8);
    bus_read(2'd0, d); check("R7 kept byte", d, 8'h11);
    bus_read(2'd1, d); check("R7 overrun cleared", d, 8'h20);

    // R10 glitch rejected
    @(negedge clk); serial_in = 1'b0;
    repeat (12) @(negedge clk); serial_in = 1'b1;
    repeat (700) @(negedge clk);
    bus_read(2'd1, d); check("R10 no byte", d, 8'h20);

    // R8 masked receive interrupt
    bus_write(2'd2, 8'h40);
    send_frame(8'h7E, 1'b1);
    check("R8 irq_rx masked", {7'd0, irq_rx}, 8'h00);
    bus_read(2'd0, d); check("R8 masked data", d, 8'h7E);

    // R6, R4 back-to-back transmit
    queue_tx(8'h5A);
    #1 bus_read(2'd1, d); check("R6 empty after load", d[5:5], 1'b1);
    queue_tx(8'hC3);
    bus_read(2'd1, d); check("R6 empty cleared", {7'd0, d[5]}, 8'h00);
    bus_read(2'd0, d); check("R1 write keeps rx", d, 8'h7E);
    for (int i = 0; i < 3000; i++) begin
      bus_read(2'd1, d);
      if (d[5]) break;
    end
    check("R4 no done with queued", {6'd0, d[6], d[5]}, 8'h01);
    for (int i = 0; i < 3000 && !irq_tx; i++) @(negedge clk);
    bus_read(2'd1, d); check("R4 done set", d, 8'h60);
    check("R8 irq_tx on", {7'd0, irq_tx}, 8'h01);

    // R5 acknowledge clears
    @(negedge clk); irq_ack_tx = 1'b1;
    @(negedge clk); irq_ack_tx = 1'b0;
    bus_read(2'd1, d); check("R5 ack clears", d, 8'h20);

    // R5 write-one clears, write-zero does not
    queue_tx(8'h81);
    for (int i = 0; i < 3000 && !irq_tx; i++) @(negedge clk);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, d); check("R5 write zero", d, 8'h60);
    bus_write(2'd1, 8'h40);
    bus_read(2'd1, d); check("R5 write one", d, 8'h20);
    check("R5 irq_tx off", {7'd0, irq_tx}, 8'h00);

    repeat (50) @(negedge clk);
    check("R9 frames consumed", 8'(exp_q.size()), 8'h00);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule